// File: doc/BRIEF.md
# Multi-Sensor Reset and Resync Sequencer

This block is the per-channel control point for a thermal camera's sensor interface. Software writes an 8-bit control word with a one-cycle strobe. The word sets the sensor's reset and power-down levels, its master clock enable, and the enable and reset of the video SPI receiver. It can also start one of two timed sequences. Every duration is measured in whole milliseconds, taken from the rising edges of a 1 kHz square wave that is sampled in the block's clock domain.

The first sequence is a master reset that all channels share. A channel raises a one-cycle request on `ext_seq_out`. The chip ORs these requests from the four channels and returns the result to every channel on `ext_seq_in`. Each channel then holds its sensor in reset for `RST_ON_MS`, waits `RST_WAIT_MS`, and gives one start-of-frame pulse so the downstream frame sequencer moves on. The manual reset level is shared the same way, through `ext_rst_out` and `ext_rst_in`. The second sequence is local to the channel. It holds the SPI receiver disabled for `SPI_HOLD_MS` and then turns it back on with its reset released.

Top module: `sensor_reset_sequencer`

## Requirements
- R1: A millisecond tick comes only from a rising edge of `ms_sq_in`, after synchronisation. While the square wave does not toggle, no sequence timer advances.
- R2: The reset field is `cmd_data[1:0]` and takes effect on a write. Code 1 asserts power-down (`sns_pwdn_n`=0) and the manual reset. Code 2 releases power-down and asserts the manual reset. Code 3 releases both. Code 0 leaves both unchanged.
- R3: The clock field is `cmd_data[5:4]`. Bit 5 qualifies the write and bit 4 is the new `sns_clk_en`. Codes 0 and 1 leave it unchanged.
- R4: `cmd_data[2]` is a strobe and is not stored. A write with it set makes `ext_seq_out` high for exactly the one cycle after the write edge.
- R5: A high `ext_seq_in` starts the reset sequence. `sns_rst_n` then stays low for `RST_ON_MS` ticks, which is between (N-1)*P+1 and N*P clocks for a square period of P clocks.
- R6: After `sns_rst_n` is released, `sof` pulses high for exactly one cycle on the `RST_WAIT_MS`-th tick. That is RST_WAIT_MS*P-1 clocks after the first cycle in which `sns_rst_n` reads high.
- R7: A new request while a sequence is running restarts it from the reset-on phase. The earlier run then gives no `sof`.
- R8: `ext_rst_out` carries this channel's manual reset. `sns_rst_n` is low whenever `ext_rst_in` is high, one cycle later.
- R9: The SPI field is `cmd_data[7:6]`. Code 1 sets `rx_rst`=1 and `rx_en`=0. Code 2 sets both to 0. Code 3 sets `rx_rst`=0 and `rx_en`=1. Code 0 leaves both unchanged.
- R10: A write with `cmd_data[3]` set drives `rx_en` low for `SPI_HOLD_MS` ticks. Afterwards `rx_en`=1 and `rx_rst`=0, whatever the earlier SPI settings were.
- R11: After reset: `sns_rst_n`=0, `sns_pwdn_n`=1, `sns_clk_en`=0, `rx_en`=0, `rx_rst`=1, `sof`=0, `ext_seq_out`=0, `ext_rst_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_sq_in | input | 1 | 1 kHz square wave, asynchronous |
| cmd_wr | input | 1 | Control word write strobe |
| cmd_data | input | CMD_W | Control word |
| ext_rst_in | input | 1 | OR of all channels' manual reset requests |
| ext_seq_in | input | 1 | OR of all channels' sequence requests |
| ext_rst_out | output | 1 | This channel's manual reset request |
| ext_seq_out | output | 1 | This channel's one-cycle sequence request |
| sns_rst_n | output | 1 | Sensor reset, active low |
| sns_pwdn_n | output | 1 | Sensor power-down, active low |
| sns_clk_en | output | 1 | Sensor master clock enable |
| rx_rst | output | 1 | SPI receiver reset |
| rx_en | output | 1 | SPI receiver enable |
| sof | output | 1 | Synthetic start-of-frame pulse |

## Verification
The bench starts the reset and SPI sequences at every phase offset across one square-wave period, so any tick miscount appears as an off-by-one-millisecond length. It also checks that a restart during the pause cancels the pending frame pulse. A design that ignored a restart would pulse early. A design that let a "no change" code or an unqualified clock write through would alter stored levels. A design that counted master clocks instead of square-wave edges would run its timer on while the bench holds the square wave still. A request that comes in only from another channel must start the sequence too.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {RS_IDLE, RS_ON, RS_WAIT} rs_state_e;
  localparam int RST_FLD_LSB = 0;
  localparam int SEQ_BIT     = 2;
  localparam int SPI_SEQ_BIT = 3;
  localparam int CLK_FLD_LSB = 4;
  localparam int SPI_FLD_LSB = 6;
endpackage

// File: rtl/srs_ms_tick.sv
module srs_ms_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sq_in,
  output logic tick
);
  // stages [SYNC_STAGES-1:0] synchronise, top stage holds previous sample
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      tick <= 1'b0;
    end else begin
      sh   <= {sh[SYNC_STAGES-1:0], sq_in};
      tick <= sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
    end
  end
endmodule

// File: rtl/srs_ctrl_regs.sv
module srs_ctrl_regs
  import srs_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CMD_W-1:0] data,
  input  logic             spi_done,
  output logic             man_rst,
  output logic             pwdn,
  output logic             clk_en,
  output logic             spi_en,
  output logic             spi_rst,
  output logic             seq_req,
  output logic             spi_go
);
  logic [1:0] rst_fld, clk_fld, spi_fld;

  assign rst_fld = data[RST_FLD_LSB +: 2];
  assign clk_fld = data[CLK_FLD_LSB +: 2];
  assign spi_fld = data[SPI_FLD_LSB +: 2];
  assign spi_go  = wr & data[SPI_SEQ_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      man_rst <= 1'b1;
      pwdn    <= 1'b0;
      clk_en  <= 1'b0;
      spi_en  <= 1'b0;
      spi_rst <= 1'b1;
      seq_req <= 1'b0;
    end else begin
      seq_req <= wr & data[SEQ_BIT];
      if (spi_done) begin
        spi_en  <= 1'b1;
        spi_rst <= 1'b0;
      end
      if (wr) begin
        unique case (rst_fld)
          2'd1: begin pwdn <= 1'b1; man_rst <= 1'b1; end
          2'd2: begin pwdn <= 1'b0; man_rst <= 1'b1; end
          2'd3: begin pwdn <= 1'b0; man_rst <= 1'b0; end
          default: ;
        endcase
        if (clk_fld[1]) clk_en <= clk_fld[0];
        unique case (spi_fld)
          2'd1: begin spi_rst <= 1'b1; spi_en <= 1'b0; end
          2'd2: begin spi_rst <= 1'b0; spi_en <= 1'b0; end
          2'd3: begin spi_rst <= 1'b0; spi_en <= 1'b1; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/srs_rst_seq.sv
module srs_rst_seq
  import srs_pkg::*;
#(
  parameter int ON_MS   = 5,
  parameter int WAIT_MS = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic seq_on,
  output logic sof
);
  localparam int MAXV = (ON_MS > WAIT_MS) ? ON_MS : WAIT_MS;
  localparam int CW   = $clog2(MAXV + 1);

  rs_state_e     state;
  logic [CW-1:0] cnt;

  assign seq_on = (state == RS_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RS_IDLE;
      cnt   <= '0;
      sof   <= 1'b0;
    end else begin
      sof <= 1'b0;
      if (start) begin
        state <= RS_ON;
        cnt   <= '0;
      end else if (tick) begin
        unique case (state)
          RS_ON: begin
            if (cnt == CW'(ON_MS - 1)) begin
              state <= RS_WAIT;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          RS_WAIT: begin
            if (cnt == CW'(WAIT_MS - 1)) begin
              state <= RS_IDLE;
              cnt   <= '0;
              sof   <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/srs_spi_seq.sv
module srs_spi_seq #(
  parameter int HOLD_MS = 185
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(HOLD_MS + 1);

  logic [CW-1:0] cnt;

  assign done = busy & tick & ~start & (cnt == CW'(HOLD_MS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sensor_reset_sequencer.sv
module sensor_reset_sequencer #(
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_ON_MS   = 5,
  parameter int RST_WAIT_MS = 2000,
  parameter int SPI_HOLD_MS = 185
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_sq_in,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             ext_rst_in,
  input  logic             ext_seq_in,
  output logic             ext_rst_out,
  output logic             ext_seq_out,
  output logic             sns_rst_n,
  output logic             sns_pwdn_n,
  output logic             sns_clk_en,
  output logic             rx_rst,
  output logic             rx_en,
  output logic             sof
);
  logic ms_tick;
  logic man_rst, pwdn, spi_en, spi_rst, spi_go;
  logic seq_on, spi_busy, spi_done;

  srs_ms_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .sq_in(ms_sq_in), .tick(ms_tick)
  );

  srs_ctrl_regs #(.CMD_W(CMD_W)) u_regs (
    .clk(clk), .rst(rst), .wr(cmd_wr), .data(cmd_data),
    .spi_done(spi_done), .man_rst(man_rst), .pwdn(pwdn),
    .clk_en(sns_clk_en), .spi_en(spi_en), .spi_rst(spi_rst),
    .seq_req(ext_seq_out), .spi_go(spi_go)
  );

  // shared sequence starts only from the ORed return path
  srs_rst_seq #(.ON_MS(RST_ON_MS), .WAIT_MS(RST_WAIT_MS)) u_rseq (
    .clk(clk), .rst(rst), .start(ext_seq_in), .tick(ms_tick),
    .seq_on(seq_on), .sof(sof)
  );

  srs_spi_seq #(.HOLD_MS(SPI_HOLD_MS)) u_sseq (
    .clk(clk), .rst(rst), .start(spi_go), .tick(ms_tick),
    .busy(spi_busy), .done(spi_done)
  );

  assign ext_rst_out = man_rst;
  assign sns_pwdn_n  = ~pwdn;

  always_ff @(posedge clk) begin
    if (rst) begin
      sns_rst_n <= 1'b0;
      rx_en     <= 1'b0;
      rx_rst    <= 1'b1;
    end else begin
      sns_rst_n <= ~(ext_rst_in | seq_on);
      rx_en     <= spi_en & ~spi_busy;
      rx_rst    <= spi_rst | spi_busy;
    end
  end
endmodule

// File: rtl/sensor_reset_sequencer_chk.sv
module sensor_reset_sequencer_chk #(
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_wr,
  input logic [CMD_W-1:0] cmd_data,
  input logic             ms_tick,
  input logic             seq_on,
  input logic             ext_seq_out,
  input logic             sns_rst_n,
  input logic             sns_pwdn_n,
  input logic             rx_en,
  input logic             sof
);
  AST_SOF_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    sof |-> $past(ms_tick)); // R1
  AST_PWDN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cmd_wr && cmd_data[1:0] != 2'd0) |=> $stable(sns_pwdn_n)); // R2
  AST_SEQ_STROBE: assert property (@(posedge clk) disable iff (rst)
    ext_seq_out |-> $past(cmd_wr && cmd_data[2])); // R4
  AST_RST_LOW_IN_ON: assert property (@(posedge clk) disable iff (rst)
    seq_on |=> !sns_rst_n); // R5
  AST_SOF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof); // R6
  AST_RX_OFF_ON_RESYNC: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_data[3]) |=> ##1 !rx_en); // R10
endmodule

bind sensor_reset_sequencer sensor_reset_sequencer_chk #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
  .ms_tick(ms_tick), .seq_on(seq_on), .ext_seq_out(ext_seq_out),
  .sns_rst_n(sns_rst_n), .sns_pwdn_n(sns_pwdn_n), .rx_en(rx_en), .sof(sof)
);

// File: tb/sensor_reset_sequencer_tb.sv
module sensor_reset_sequencer_tb;
  localparam int P  = 20;
  localparam int ON = 2;
  localparam int WT = 5;
  localparam int SP = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       sq = 1'b0, sq_run = 1'b1;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       other_rst = 1'b0, other_seq = 1'b0;
  logic       ext_rst_out, ext_seq_out, sns_rst_n, sns_pwdn_n, sns_clk_en;
  logic       rx_rst, rx_en, sof;
  int tests = 0, fails = 0, sof_cnt = 0, ph = 0;

  sensor_reset_sequencer #(.RST_ON_MS(ON), .RST_WAIT_MS(WT), .SPI_HOLD_MS(SP)) u_dut (
    .clk(clk), .rst(rst), .ms_sq_in(sq), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .ext_rst_in(ext_rst_out | other_rst), .ext_seq_in(ext_seq_out | other_seq),
    .ext_rst_out(ext_rst_out), .ext_seq_out(ext_seq_out), .sns_rst_n(sns_rst_n),
    .sns_pwdn_n(sns_pwdn_n), .sns_clk_en(sns_clk_en), .rx_rst(rx_rst),
    .rx_en(rx_en), .sof(sof)
  );

  always @(negedge clk) begin
    if (sq_run) begin
      ph = ph + 1;
      if (ph == P/2) begin ph = 0; sq = ~sq; end
    end
    if (sof) sof_cnt = sof_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [7:0] d);
    @(negedge clk); cmd_wr = 1'b1; cmd_data = d;
    @(negedge clk); cmd_wr = 1'b0; cmd_data = 8'h00;
  endtask

  task automatic measure_rst(output int low, output int pause, output int sofw);
    int w = 0;
    while (sns_rst_n && w < 50) begin w++; @(negedge clk); end
    low = 0;
    while (!sns_rst_n && low < 5000) begin low++; @(negedge clk); end
    pause = 0;
    while (!sof && pause < 5000) begin pause++; @(negedge clk); end
    sofw = 0;
    while (sof && sofw < 10) begin sofw++; @(negedge clk); end
  endtask

  task automatic measure_rx(output int low);
    @(negedge clk);
    low = 0;
    while (!rx_en && low < 5000) begin low++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int low, pause, sofw, snap;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(sns_rst_n == 0 && sns_pwdn_n == 1 && sns_clk_en == 0, "R11 sensor pins", int'(sns_rst_n), 0);
    chk(rx_en == 0 && rx_rst == 1 && sof == 0, "R11 rx/sof", int'(rx_en), 0);
    chk(ext_seq_out == 0 && ext_rst_out == 1, "R11 ext", int'(ext_rst_out), 1);

    // R2 reset field
    wr_cmd(8'h01); @(negedge clk);
    chk(sns_pwdn_n == 0 && sns_rst_n == 0, "R2 code1", int'(sns_pwdn_n), 0);
    wr_cmd(8'h00); @(negedge clk);
    chk(sns_pwdn_n == 0 && sns_rst_n == 0, "R2 code0 keeps", int'(sns_pwdn_n), 0);
    wr_cmd(8'h02); @(negedge clk);
    chk(sns_pwdn_n == 1 && sns_rst_n == 0, "R2 code2", int'(sns_rst_n), 0);
    wr_cmd(8'h03); @(negedge clk);
    chk(sns_pwdn_n == 1 && sns_rst_n == 1, "R2 code3", int'(sns_rst_n), 1);
    chk(ext_rst_out == 0, "R8 ext_rst_out follows manual reset", int'(ext_rst_out), 0);
    wr_cmd(8'h00); @(negedge clk);
    chk(sns_pwdn_n == 1 && sns_rst_n == 1, "R2 code0 keeps released", int'(sns_rst_n), 1);

    // R3 clock field
    wr_cmd(8'h10); @(negedge clk);
    chk(sns_clk_en == 0, "R3 code1 no change", int'(sns_clk_en), 0);
    wr_cmd(8'h30); @(negedge clk);
    chk(sns_clk_en == 1, "R3 enable", int'(sns_clk_en), 1);
    wr_cmd(8'h10); @(negedge clk);
    chk(sns_clk_en == 1, "R3 code1 keeps", int'(sns_clk_en), 1);
    wr_cmd(8'h20); @(negedge clk);
    chk(sns_clk_en == 0, "R3 disable", int'(sns_clk_en), 0);

    // R9 SPI field
    wr_cmd(8'hC0); @(negedge clk);
    chk(rx_en == 1 && rx_rst == 0, "R9 code3", int'(rx_en), 1);
    wr_cmd(8'h40); @(negedge clk);
    chk(rx_en == 0 && rx_rst == 1, "R9 code1", int'(rx_rst), 1);
    wr_cmd(8'h80); @(negedge clk);
    chk(rx_en == 0 && rx_rst == 0, "R9 code2", int'(rx_rst), 0);
    wr_cmd(8'hC0); @(negedge clk);
    wr_cmd(8'h00); @(negedge clk);
    chk(rx_en == 1 && rx_rst == 0, "R9 code0 keeps", int'(rx_en), 1);

    // R8 shared manual reset from another channel
    other_rst = 1'b1; @(negedge clk); @(negedge clk);
    chk(sns_rst_n == 0 && ext_rst_out == 0, "R8 external reset", int'(sns_rst_n), 0);
    other_rst = 1'b0; @(negedge clk); @(negedge clk);
    chk(sns_rst_n == 1, "R8 external release", int'(sns_rst_n), 1);

    // R4/R5/R6 phase sweep of the reset sequence
    for (int k = 0; k < P; k++) begin
      repeat (k) @(negedge clk);
      wr_cmd(8'h04);
      chk(ext_seq_out == 1, "R4 strobe high", int'(ext_seq_out), 1);
      @(negedge clk);
      chk(ext_seq_out == 0, "R4 strobe one cycle", int'(ext_seq_out), 0);
      measure_rst(low, pause, sofw);
      chk(low >= (ON-1)*P+1 && low <= ON*P, "R5 reset-on length", low, ON*P);
      chk(pause == WT*P-1, "R6 pause to sof", pause, WT*P-1);
      chk(sofw == 1, "R6 sof width", sofw, 1);
    end
    wr_cmd(8'h00);
    chk(ext_seq_out == 0, "R4 bit not stored", int'(ext_seq_out), 0);

    // R5 sequence started by another channel
    @(negedge clk); other_seq = 1'b1; @(negedge clk); other_seq = 1'b0;
    measure_rst(low, pause, sofw);
    chk(low >= (ON-1)*P+1 && low <= ON*P, "R5 external start length", low, ON*P);
    chk(pause == WT*P-1 && sofw == 1, "R6 external start sof", pause, WT*P-1);

    // R7 restart during the pause
    wr_cmd(8'h04);
    while (sns_rst_n) @(negedge clk);
    while (!sns_rst_n) @(negedge clk);
    repeat (2*P) @(negedge clk);
    snap = sof_cnt;
    wr_cmd(8'h04);
    measure_rst(low, pause, sofw);
    chk(sof_cnt == snap + 1, "R7 only one sof after restart", sof_cnt - snap, 1);
    chk(low >= (ON-1)*P+1 && low <= ON*P, "R7 restart length", low, ON*P);
    chk(pause == WT*P-1, "R7 restart pause", pause, WT*P-1);

    // R10 SPI resync phase sweep
    for (int k = 0; k < P; k++) begin
      repeat (k) @(negedge clk);
      if (k % 2 == 1) wr_cmd(8'h40);
      wr_cmd(8'h08);
      measure_rx(low);
      chk(low >= (SP-1)*P+1 && low <= SP*P, "R10 hold length", low, SP*P);
      chk(rx_en == 1 && rx_rst == 0, "R10 re-enabled", int'(rx_rst), 0);
    end

    // R1 frozen square wave stops timers
    sq_run = 1'b0;
    wr_cmd(8'h08);
    repeat (5*P) @(negedge clk);
    chk(rx_en == 0, "R1 no tick without edges", int'(rx_en), 0);
    sq_run = 1'b1;
    low = 0;
    while (!rx_en && low < 5000) begin low++; @(negedge clk); end
    chk(low >= (SP-1)*P && low <= SP*P+4, "R1 resumes on edges", low, SP*P);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule